// File: doc/BRIEF.md
# Output Pixel Format Packer

The block takes 32-bit ARGB pixels (alpha in bits 31:24, red 23:16, green 15:8, blue 7:0) from a valid/ready stream. It packs each pixel into one of five output layouts and presents the packed word on an output valid/ready stream. A four-bit byte enable comes with the word and marks the bytes that carry pixel data. Before packing, the alpha value can be inverted and red can be exchanged with blue. After packing, the bytes can be exchanged in pairs.

A fill mode replaces the input stream with a constant colour presented at a port. While fill mode is active, the block issues that colour, packed, on every cycle in which its output register can accept a word. An unsupported format code raises an error output and stops new words from entering the output register.

The block has one output register. A pixel that is accepted at a clock edge is on the output from that edge until it is taken.

Top module: `pix_pack_top`

## Requirements
- R1: Format code 0 outputs {a,r,g,b} unchanged. Format code 1 outputs {8'h00,r,g,b}. In both cases each channel keeps its 8-bit position.
- R2: Format code 2 outputs {16'h0, r[7:3], g[7:2], b[7:3]}.
- R3: Format code 3 outputs {16'h0, a[7], r[7:3], g[7:3], b[7:3]}.
- R4: Format code 4 outputs {16'h0, a[7:4], r[7:4], g[7:4], b[7:4]}.
- R5: When alpha_inv_i is 1, alpha is replaced by its bitwise complement before packing.
- R6: When rb_swap_i is 1, the red and blue channels are exchanged before packing.
- R7: When byte_swap_i is 1, the packed word and its byte enable both have byte lanes 0 and 1 exchanged, and lanes 2 and 3 exchanged. This happens after packing.
- R8: Without byte swap, the byte enable is 4'b1111 for code 0, 4'b0111 for code 1 and 4'b0011 for codes 2 to 4.
- R9: When fill_i is 1, the source pixel is fill_color_i (same channel layout as the input) and in_ready_o is 0. A packed fill word is loaded at every edge where the output register is empty or is being drained.
- R10: Codes 5, 6 and 7 set err_o to 1 in the same cycle. While err_o is 1, in_ready_o is 0 and no new word is loaded, so out_valid_o drops once a held word has been taken.
- R11: A pixel accepted at an edge appears on the output from that edge on. While out_valid_o is 1 and out_ready_i is 0, the output word and byte enable hold their values.
- R12: During reset and after it, out_valid_o is 0 until a word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 3 | Output format code |
| alpha_inv_i | input | 1 | Invert alpha before packing |
| rb_swap_i | input | 1 | Exchange red and blue before packing |
| byte_swap_i | input | 1 | Exchange bytes in pairs after packing |
| fill_i | input | 1 | Use the constant colour as the source |
| fill_color_i | input | 32 | Constant colour, ARGB layout |
| in_valid_i | input | 1 | Input pixel valid |
| in_data_i | input | 32 | Input pixel, ARGB layout |
| in_ready_o | output | 1 | Input pixel accepted when valid |
| out_valid_o | output | 1 | Packed word valid |
| out_ready_i | input | 1 | Downstream takes the word |
| out_data_o | output | 32 | Packed word |
| out_be_o | output | 4 | Byte enable of the packed word |
| err_o | output | 1 | Unsupported format code |

## Verification
Packed words are due on the edge after acceptance. The bench decides at mid-cycle whether a transfer will happen at the coming edge, using the same settled ports the design sees. It queues the expected word computed at that moment and compares the queue head whenever a word is taken.

The err_o and in_ready_o outputs are combinational, so they are checked in the same half-cycle as their inputs. Directed single-pixel transfers check literal values one edge after a lone accept. Each directed transfer is fully drained before the next one starts.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;
  localparam int unsigned CH_W  = 8;
  localparam int unsigned NCH   = 4;
  localparam int unsigned PIX_W = CH_W * NCH;
  localparam int unsigned BE_W  = PIX_W / 8;
  localparam int unsigned FMT_W = 3;

  typedef enum logic [FMT_W-1:0] {
    FMT_A8R8G8B8 = 3'd0,
    FMT_R8G8B8   = 3'd1,
    FMT_R5G6B5   = 3'd2,
    FMT_A1R5G5B5 = 3'd3,
    FMT_A4R4G4B4 = 3'd4
  } fmt_e;

  typedef struct packed {
    logic [CH_W-1:0] a;
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } argb_t;
endpackage

// File: rtl/pix_pack_prep.sv
module pix_pack_prep
  import pix_pack_pkg::*;
(
  input  argb_t pix_i,
  input  logic  alpha_inv_i,
  input  logic  rb_swap_i,
  output argb_t pix_o
);
  always_comb begin
    pix_o.a = alpha_inv_i ? ~pix_i.a : pix_i.a;
    pix_o.g = pix_i.g;
    pix_o.r = rb_swap_i ? pix_i.b : pix_i.r;
    pix_o.b = rb_swap_i ? pix_i.r : pix_i.b;
  end
endmodule

// File: rtl/pix_pack_fmt.sv
module pix_pack_fmt
  import pix_pack_pkg::*;
(
  input  argb_t            pix_i,
  input  logic [FMT_W-1:0] fmt_i,
  output logic [PIX_W-1:0] data_o,
  output logic [BE_W-1:0]  be_o,
  output logic             bad_o
);
  localparam int unsigned HALF = PIX_W / 2;

  always_comb begin
    data_o = '0;
    be_o   = '0;
    bad_o  = 1'b0;
    unique case (fmt_i)
      FMT_A8R8G8B8: begin
        data_o = pix_i;
        be_o   = 4'b1111;
      end
      FMT_R8G8B8: begin
        data_o = {{CH_W{1'b0}}, pix_i.r, pix_i.g, pix_i.b};
        be_o   = 4'b0111;
      end
      FMT_R5G6B5: begin
        data_o = {{HALF{1'b0}}, pix_i.r[7:3], pix_i.g[7:2], pix_i.b[7:3]};
        be_o   = 4'b0011;
      end
      FMT_A1R5G5B5: begin
        data_o = {{HALF{1'b0}}, pix_i.a[7], pix_i.r[7:3], pix_i.g[7:3], pix_i.b[7:3]};
        be_o   = 4'b0011;
      end
      FMT_A4R4G4B4: begin
        data_o = {{HALF{1'b0}}, pix_i.a[7:4], pix_i.r[7:4], pix_i.g[7:4], pix_i.b[7:4]};
        be_o   = 4'b0011;
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pix_pack_bswap.sv
module pix_pack_bswap #(
  parameter int unsigned NBYTES = 4
) (
  input  logic                  en_i,
  input  logic [NBYTES*8-1:0]   data_i,
  input  logic [NBYTES-1:0]     be_i,
  output logic [NBYTES*8-1:0]   data_o,
  output logic [NBYTES-1:0]     be_o
);
  localparam int unsigned NPAIR = NBYTES / 2;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int unsigned LO = 2 * p;
    localparam int unsigned HI = 2 * p + 1;
    assign data_o[LO*8 +: 8] = en_i ? data_i[HI*8 +: 8] : data_i[LO*8 +: 8];
    assign data_o[HI*8 +: 8] = en_i ? data_i[LO*8 +: 8] : data_i[HI*8 +: 8];
    assign be_o[LO]          = en_i ? be_i[HI] : be_i[LO];
    assign be_o[HI]          = en_i ? be_i[LO] : be_i[HI];
  end
endmodule

// File: rtl/pix_pack_top.sv
module pix_pack_top
  import pix_pack_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       fmt_i,
  input  logic             alpha_inv_i,
  input  logic             rb_swap_i,
  input  logic             byte_swap_i,
  input  logic             fill_i,
  input  logic [31:0]      fill_color_i,
  input  logic             in_valid_i,
  input  logic [31:0]      in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [31:0]      out_data_o,
  output logic [3:0]       out_be_o
,
  output logic             err_o
);
  argb_t            src, prep;
  logic [PIX_W-1:0] pk_data, sw_data;
  logic [BE_W-1:0]  pk_be, sw_be;
  logic             bad, slot_free, src_valid, load;

  assign src = fill_i ? argb_t'(fill_color_i) : argb_t'(in_data_i);

  pix_pack_prep u_prep (
    .pix_i       (src),
    .alpha_inv_i (alpha_inv_i),
    .rb_swap_i   (rb_swap_i),
    .pix_o       (prep)
  );

  pix_pack_fmt u_fmt (
    .pix_i  (prep),
    .fmt_i  (fmt_i),
    .data_o (pk_data),
    .be_o   (pk_be),
    .bad_o  (bad)
  );

  pix_pack_bswap #(.NBYTES(BE_W)) u_bswap (
    .en_i   (byte_swap_i),
    .data_i (pk_data),
    .be_i   (pk_be),
    .data_o (sw_data),
    .be_o   (sw_be)
  );

  assign slot_free  = !out_valid_o || out_ready_i;
  assign src_valid  = fill_i || in_valid_i;
  assign load       = src_valid && !bad && slot_free;
  assign in_ready_o = !fill_i && !bad && slot_free;
  assign err_o      = bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_be_o    <= '0;
    end else begin
      if (load) begin
        out_valid_o <= 1'b1;
        out_data_o  <= sw_data;
        out_be_o    <= sw_be;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pix_pack_chk.sv
module pix_pack_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fill_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_data_o,
  input logic [3:0]  out_be_o,
  input logic        err_o
);
  // R11
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_be_o)));

  // R10
  err_blocks_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !in_ready_o);

  // R10
  err_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && (!out_valid_o || out_ready_i)) |=> !out_valid_o);

  // R9
  fill_blocks_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> !in_ready_o);

  // R8
  be_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($countones(out_be_o) >= 2));
endmodule

bind pix_pack_top pix_pack_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fill_i      (fill_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_be_o    (out_be_o),
  .err_o       (err_o)
);

// File: tb/pix_pack_top_tb_top.sv
`timescale 1ns/1ps
module pix_pack_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  fmt_i = '0;
  logic        alpha_inv_i = 1'b0, rb_swap_i = 1'b0, byte_swap_i = 1'b0, fill_i = 1'b0;
  logic [31:0] fill_color_i = '0, in_data_i = '0;
  logic        in_valid_i = 1'b0, out_ready_i = 1'b0;
  logic        in_ready_o, out_valid_o, err_o;
  logic [31:0] out_data_o;
  logic [3:0]  out_be_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [35:0] expq[$];

  always #2.5 clk_i = ~clk_i;

  pix_pack_top dut_i (.*);

  function automatic logic [35:0] model(input logic [31:0] p, input logic [2:0] f,
                                        input logic ai, input logic rbs, input logic bs);
    logic [7:0] a, r, g, b, t;
    logic [31:0] d;
    logic [3:0] e;
    a = p[31:24]; r = p[23:16]; g = p[15:8]; b = p[7:0];
    if (ai) a = 8'hFF - a;
    if (rbs) begin t = r; r = b; b = t; end
    case (f)
      3'd0: begin d = {a, r, g, b}; e = 4'hF; end
      3'd1: begin d = {8'd0, r, g, b}; e = 4'h7; end
      3'd2: begin d = {16'd0, r[7:3], g[7:2], b[7:3]}; e = 4'h3; end
      3'd3: begin d = {16'd0, a[7], r[7:3], g[7:3], b[7:3]}; e = 4'h3; end
      default: begin d = {16'd0, a[7:4], r[7:4], g[7:4], b[7:4]}; e = 4'h3; end
    endcase
    if (bs) begin
      d = {d[23:16], d[31:24], d[7:0], d[15:8]};
      e = {e[2], e[3], e[0], e[1]};
    end
    return {e, d};
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drain();
    in_valid_i = 1'b0; fill_i = 1'b0; out_ready_i = 1'b1;
    repeat (3) @(negedge clk_i);
    expq.delete();
  endtask

  // one pixel, checked against a literal one edge after acceptance
  task automatic direct(input string req, input logic [2:0] f, input logic ai, input logic rbs,
                        input logic bs, input logic [31:0] p, input logic [35:0] exp);
    drain();
    fmt_i = f; alpha_inv_i = ai; rb_swap_i = rbs; byte_swap_i = bs;
    in_data_i = p; in_valid_i = 1'b1; out_ready_i = 1'b0;
    #1 chk({req, " ready"}, {35'd0, in_ready_o}, 36'd1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk({req, " valid"}, {35'd0, out_valid_o}, 36'd1);
    chk(req, {out_be_o, out_data_o}, exp);
    @(negedge clk_i);
    chk({req, " hold R11"}, {out_be_o, out_data_o}, exp);
  endtask

  // random traffic with scoreboard; mode 0 stream, 1 fill
  task automatic run_phase(input int n, input bit fill_mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      fmt_i       = 3'($urandom_range(0, 4));
      alpha_inv_i = 1'($urandom);
      rb_swap_i   = 1'($urandom);
      byte_swap_i = 1'($urandom);
      fill_i      = fill_mode;
      fill_color_i = $urandom;
      in_valid_i  = 1'($urandom);
      in_data_i   = $urandom;
      out_ready_i = ($urandom_range(0, 3) != 0);
      #1;
      if (out_valid_o && out_ready_i) begin
        if (expq.size() == 0) chk("R11 spurious", 36'd1, 36'd0);
        else chk(fill_mode ? "R9 fill word" : "R1 R7 packed word", {out_be_o, out_data_o},
                 expq.pop_front());
      end
      if (fill_mode) chk("R9 ready low", {35'd0, in_ready_o}, 36'd0);
      else chk("R11 ready", {35'd0, in_ready_o}, {35'd0, (!out_valid_o || out_ready_i)});
      if (fill_mode) begin
        if (!out_valid_o || out_ready_i)
          expq.push_back(model(fill_color_i, fmt_i, alpha_inv_i, rb_swap_i, byte_swap_i));
      end else if (in_valid_i && in_ready_o) begin
        expq.push_back(model(in_data_i, fmt_i, alpha_inv_i, rb_swap_i, byte_swap_i));
      end
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    #1 chk("R12 reset valid", {35'd0, out_valid_o}, 36'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 after reset", {35'd0, out_valid_o}, 36'd0);

    direct("R1 argb8888", 3'd0, 0, 0, 0, 32'h80FF8040, {4'hF, 32'h80FF8040});
    direct("R1 R8 rgb888", 3'd1, 0, 0, 0, 32'h80FF8040, {4'h7, 32'h00FF8040});
    direct("R2 rgb565", 3'd2, 0, 0, 0, 32'h80FF8040, {4'h3, 32'h0000FC08});
    direct("R3 argb1555", 3'd3, 0, 0, 0, 32'h80FF8040, {4'h3, 32'h0000FE08});
    direct("R4 argb4444", 3'd4, 0, 0, 0, 32'h80FF8040, {4'h3, 32'h00008F84});
    direct("R5 alpha inv", 3'd3, 1, 0, 0, 32'h80FF8040, {4'h3, 32'h00007E08});
    direct("R6 rb swap", 3'd0, 0, 1, 0, 32'h80FF8040, {4'hF, 32'h804080FF});
    direct("R7 bswap 32", 3'd0, 0, 0, 1, 32'h80FF8040, {4'hF, 32'hFF804080});
    direct("R7 bswap 24", 3'd1, 0, 0, 1, 32'h80FF8040, {4'hB, 32'hFF004080});
    direct("R7 bswap 16", 3'd2, 0, 0, 1, 32'h80FF8040, {4'h3, 32'h000008FC});

    // fill directed
    drain();
    fmt_i = 3'd0; alpha_inv_i = 0; rb_swap_i = 0; byte_swap_i = 0;
    fill_color_i = 32'h11223344; fill_i = 1'b1; in_valid_i = 1'b0; out_ready_i = 1'b1;
    @(negedge clk_i);
    chk("R9 fill valid", {35'd0, out_valid_o}, 36'd1);
    chk("R9 fill data", {out_be_o, out_data_o}, {4'hF, 32'h11223344});
    drain();

    run_phase(3000, 1'b0);
    drain();
    run_phase(500, 1'b1);
    drain();

    // invalid codes
    for (int c = 5; c < 8; c++) begin
      drain();
      fmt_i = 3'(c); in_valid_i = 1'b1; in_data_i = 32'hDEADBEEF;
      #1;
      chk("R10 err", {35'd0, err_o}, 36'd1);
      chk("R10 ready low", {35'd0, in_ready_o}, 36'd0);
      @(negedge clk_i);
      chk("R10 no output", {35'd0, out_valid_o}, 36'd0);
      fill_i = 1'b1;
      @(negedge clk_i);
      chk("R10 no fill output", {35'd0, out_valid_o}, 36'd0);
    end
    fmt_i = 3'd0; fill_i = 1'b0; in_valid_i = 1'b0;
    #1 chk("R10 err clear", {35'd0, err_o}, 36'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule